// File: doc/BRIEF.md
# Indexed-Programmed Degamma Lookup Unit

This block linearises pixel components before a colour-space-conversion stage. Each component is an unsigned fixed-point value with 3 integer bits and 16 fractional bits. It is mapped through a 35-point piecewise-linear curve held in registers. Thirty-three points divide the range 0 to 1.0 into 32 equal segments. Two more points give the curve's value at 3.0 and at 7.0, so inputs above 1.0 still follow a defined curve. Every channel of a pixel uses the same curve, and the mapped pixel leaves the block two cycles after it enters.

Software loads the curve through a small register interface. It first writes a start position to an index register. A second write turns on stepping, and from then on each write to the data port fills one entry and moves the pointer forward. A mode register turns the curve on or off. When the curve is off, pixels pass through unchanged.

Top module: `degamma_lut_unit`

## Requirements
- R1: After reset the mode register reads 0, the index reads 0 with stepping off, and the table holds the identity curve: entry i = i*2048 for i in 0..32, and entries 33 and 34 = 65536 (1.0).
- R2: The register map is: address 0 is mode (bit 31 enables the curve, bit 30 is a stored post-conversion enable, other bits read 0); address 1 is index control; address 2 is the data port. Reading address 2 returns the entry at the current index, or 0 when the index is 35. Reading address 3 returns 0.
- R3: A write to address 1 with bit 10 clear turns stepping off and loads the index from bits 9:0. A value of 35 or more loads 35. Address 1 reads back the index in bits 5:0 and the stepping flag in bit 10.
- R4: A write to address 1 with bit 10 set turns stepping on and leaves the index unchanged, whatever its bits 9:0 hold.
- R5: A data write with an index below 35 stores bits 16:0 at the index. The index then goes up by one if stepping is on, and stays put if stepping is off.
- R6: At index 35, a data write leaves the table and the index unchanged. Stepping past entry 34 stops at 35.
- R7: With the curve enabled and input x < 65536, the output is e[s] + (e[s+1]-e[s])*f/2048, where s = x[15:11] and f = x[10:0]. The output never leaves the range between the two points.
- R8: Inputs from 1.0 to 3.0 interpolate between entries 32 and 33, with a span of 131072. Inputs above 3.0 up to 7.0 interpolate between entries 33 and 34, with a span of 262144. Inputs above 7.0 return entry 34.
- R9: The interpolated offset is rounded to nearest, and exact halves round up (toward +infinity), including when the curve is falling.
- R10: With mode bit 31 clear, each output component equals its input component.
- R11: Output valid follows input valid exactly two cycles later. A pixel uses the table and the mode as they stood before the edge that samples it, so a write in the same cycle affects only later pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_i | input | 57 | Input pixel, channel c at bits [19c+18:19c] |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 57 | Output pixel, same packing |

## Verification
Two corner cases are hard to reach from the ports. The first is a data write to an entry in the same cycle that a pixel needs that entry. The bench points the index at the segment a chosen input uses, then issues the write and the pixel together, and follows with the same pixel again. The old and new values must then appear in that order. The second is saturation of the pointer. It is reached both by an oversized index write and by stepping through the last entry, and the index and the last entry are then read back through the data port.

// File: rtl/degamma_pkg.sv
package degamma_pkg;
   localparam logic [1:0] REG_MODE  = 2'd0;
   localparam logic [1:0] REG_INDEX = 2'd1;
   localparam logic [1:0] REG_DATA  = 2'd2;
   localparam int PRE_EN_BIT  = 31;
   localparam int POST_EN_BIT = 30;
   localparam int STEP_BIT    = 10;
   localparam int IDX_FIELD_W = 10;
endpackage

// File: rtl/degamma_table.sv
module degamma_table
   import degamma_pkg::*;
#(
   parameter int FRAC_W   = 16,
   parameter int SEG_BITS = 5,
   parameter int ENT_W    = 17,
   parameter int N_ENT    = 35,
   parameter int IDX_W    = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [1:0]                    reg_addr,
   input  logic [31:0]                   reg_wdata,
   output logic [31:0]                   reg_rdata,
   output logic                          pre_en,
   output logic [N_ENT-1:0][ENT_W-1:0]   tbl_o
);
   localparam int LAST_UNI = 2 ** SEG_BITS;
   localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(N_ENT);
   localparam logic [IDX_FIELD_W-1:0] N_ENT_F = IDX_FIELD_W'(N_ENT);

   function automatic logic [ENT_W-1:0] ident(int i);
      if (i <= LAST_UNI) return ENT_W'(i * (2 ** (FRAC_W - SEG_BITS)));
      return ENT_W'(2 ** FRAC_W);
   endfunction

   logic [IDX_W-1:0]               idx_q;
   logic                           step_q, pre_q, post_q;
   logic [N_ENT-1:0][ENT_W-1:0]    tbl_q;
   logic [IDX_FIELD_W-1:0]         idx_field;
   logic                           wr_mode, wr_idx, wr_data, idx_ok;
   logic                           unused_wdata;

   assign wr_mode   = reg_wr && (reg_addr == REG_MODE);
   assign wr_idx    = reg_wr && (reg_addr == REG_INDEX);
   assign wr_data   = reg_wr && (reg_addr == REG_DATA);
   assign idx_field = reg_wdata[IDX_FIELD_W-1:0];
   assign idx_ok    = idx_q < IDX_SAT;
   assign unused_wdata = ^reg_wdata[POST_EN_BIT-1:ENT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         step_q <= 1'b0;
         pre_q  <= 1'b0;
         post_q <= 1'b0;
         for (int i = 0; i < N_ENT; i++) tbl_q[i] <= ident(i);
      end else begin
         if (wr_mode) begin
            pre_q  <= reg_wdata[PRE_EN_BIT];
            post_q <= reg_wdata[POST_EN_BIT];
         end
         if (wr_idx) begin
            if (reg_wdata[STEP_BIT]) begin
               step_q <= 1'b1;
            end else begin
               step_q <= 1'b0;
               idx_q  <= (idx_field >= N_ENT_F) ? IDX_SAT : idx_field[IDX_W-1:0];
            end
         end
         if (wr_data && idx_ok) begin
            tbl_q[idx_q] <= reg_wdata[ENT_W-1:0];
            if (step_q) idx_q <= idx_q + 1'b1;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         REG_MODE: begin
            reg_rdata[PRE_EN_BIT]  = pre_q;
            reg_rdata[POST_EN_BIT] = post_q;
         end
         REG_INDEX: begin
            reg_rdata[IDX_W-1:0] = idx_q;
            reg_rdata[STEP_BIT]  = step_q;
         end
         REG_DATA: if (idx_ok) reg_rdata = 32'(tbl_q[idx_q]);
         default: reg_rdata = '0;
      endcase
   end

   assign pre_en = pre_q;
   assign tbl_o  = tbl_q;

   assert_idx_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_SAT);
   assert_step_keeps_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_idx && reg_wdata[STEP_BIT] |=> $stable(idx_q));
   assert_step_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data && step_q && idx_ok |=> idx_q == $past(idx_q) + 1'b1);
   assert_sat_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data && !idx_ok |=> $stable(tbl_q) && $stable(idx_q));
endmodule

// File: rtl/degamma_chan.sv
module degamma_chan #(
   parameter int FRAC_W   = 16,
   parameter int SEG_BITS = 5,
   parameter int ENT_W    = 17,
   parameter int N_ENT    = 35,
   parameter int IN_W     = 19
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic                        mid_valid,
   input  logic [IN_W-1:0]             in_x,
   input  logic                        pre_en,
   input  logic [N_ENT-1:0][ENT_W-1:0] tbl,
   output logic [IN_W-1:0]             out_y
);
   localparam int W_SEG = FRAC_W - SEG_BITS;
   localparam int NW    = FRAC_W + 2;
   localparam int W1    = NW + 1;
   localparam int SIX_W = SEG_BITS + 1;
   localparam int PW    = ENT_W + 1 + W1 + 1;
   localparam int E_A   = 2 ** SEG_BITS + 1;
   localparam int E_B   = 2 ** SEG_BITS + 2;
   localparam logic [IN_W-1:0] ONE   = IN_W'(1) << FRAC_W;
   localparam logic [IN_W-1:0] THREE = IN_W'(3) << FRAC_W;
   localparam logic [IN_W-1:0] SEVEN = IN_W'(7) << FRAC_W;
   localparam logic signed [PW-1:0] RND = PW'(1) << (NW - 1);

   logic [SEG_BITS-1:0] seg;
   logic [ENT_W-1:0]    lo_d, hi_d, lo1, hi1;
   logic [W1-1:0]       w_d, w1;
   logic [IN_W-1:0]     x1, y_q, mn, mx;
   logic                byp1;
   logic signed [ENT_W:0]  diff;
   logic signed [PW-1:0]   prod, acc, q, res;

   assign seg = in_x[FRAC_W-1 -: SEG_BITS];

   always_comb begin
      if (in_x < ONE) begin
         lo_d = tbl[seg];
         hi_d = tbl[SIX_W'(seg) + SIX_W'(1)];
         w_d  = W1'(in_x[W_SEG-1:0]) << (NW - W_SEG);
      end else if (in_x <= THREE) begin
         lo_d = tbl[E_A-1];
         hi_d = tbl[E_A];
         w_d  = W1'(in_x - ONE) << (NW - FRAC_W - 1);
      end else if (in_x <= SEVEN) begin
         lo_d = tbl[E_A];
         hi_d = tbl[E_B];
         w_d  = W1'(in_x - THREE);
      end else begin
         lo_d = tbl[E_B];
         hi_d = tbl[E_B];
         w_d  = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo1 <= '0; hi1 <= '0; w1 <= '0; x1 <= '0; byp1 <= 1'b1;
      end else if (in_valid) begin
         lo1 <= lo_d; hi1 <= hi_d; w1 <= w_d; x1 <= in_x; byp1 <= !pre_en;
      end
   end

   always_comb begin
      diff = $signed({1'b0, hi1}) - $signed({1'b0, lo1});
      prod = PW'(diff) * PW'($signed({1'b0, w1}));
      acc  = prod + RND;
      q    = acc >>> NW;
      res  = PW'($signed({1'b0, lo1})) + q;
      mn   = IN_W'((lo1 < hi1) ? lo1 : hi1);
      mx   = IN_W'((lo1 < hi1) ? hi1 : lo1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         y_q <= '0;
      else if (mid_valid) y_q <= byp1 ? x1 : IN_W'(res);
   end

   assign out_y = y_q;

   assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mid_valid && byp1 |=> y_q == $past(x1));
   assert_in_segment_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mid_valid && !byp1 |=> (y_q >= $past(mn)) && (y_q <= $past(mx)));
endmodule

// File: rtl/degamma_lut_unit.sv
module degamma_lut_unit #(
   parameter int NUM_CH   = 3,
   parameter int FRAC_W   = 16,
   parameter int SEG_BITS = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic [1:0]                  reg_addr,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 reg_rdata,
   input  logic                        pix_valid_i,
   input  logic [NUM_CH*(FRAC_W+3)-1:0] pix_i,
   output logic                        pix_valid_o,
   output logic [NUM_CH*(FRAC_W+3)-1:0] pix_o
);
   localparam int IN_W  = FRAC_W + 3;
   localparam int ENT_W = FRAC_W + 1;
   localparam int N_ENT = 2 ** SEG_BITS + 3;
   localparam int IDX_W = $clog2(N_ENT + 1);

   if (SEG_BITS >= FRAC_W) begin : g_bad_seg
      $error("SEG_BITS must be below FRAC_W");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (N_ENT >= 2 ** degamma_pkg::IDX_FIELD_W || ENT_W > degamma_pkg::POST_EN_BIT) begin : g_bad_map
      $error("table does not fit the register fields");
   end

   logic                        pre_en;
   logic [N_ENT-1:0][ENT_W-1:0] tbl;
   logic                        v1_q, v2_q;

   degamma_table #(
      .FRAC_W(FRAC_W), .SEG_BITS(SEG_BITS), .ENT_W(ENT_W), .N_ENT(N_ENT), .IDX_W(IDX_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pre_en(pre_en), .tbl_o(tbl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         v2_q <= 1'b0;
      end else begin
         v1_q <= pix_valid_i;
         v2_q <= v1_q;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      degamma_chan #(
         .FRAC_W(FRAC_W), .SEG_BITS(SEG_BITS), .ENT_W(ENT_W), .N_ENT(N_ENT), .IN_W(IN_W)
      ) u_chan (
         .clk(clk), .rst_n(rst_n), .in_valid(pix_valid_i), .mid_valid(v1_q),
         .in_x(pix_i[c*IN_W +: IN_W]), .pre_en(pre_en), .tbl(tbl),
         .out_y(pix_o[c*IN_W +: IN_W])
      );
   end

   assign pix_valid_o = v2_q;

   assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid_i |=> ##1 pix_valid_o);
   assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid_i |=> ##1 !pix_valid_o);
endmodule

// File: tb/tb_degamma_lut_unit.sv
`timescale 1ns/1ps
module tb_degamma_lut_unit;
   localparam int NC = 3;
   localparam int XW = 19;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic pix_valid_i = 1'b0, pix_valid_o;
   logic [NC*XW-1:0] pix_i = '0, pix_o;

   degamma_lut_unit dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid_i(pix_valid_i),
      .pix_i(pix_i), .pix_valid_o(pix_valid_o), .pix_o(pix_o)
   );

   always #2.5 clk = ~clk;

   int n_run = 0, n_fail = 0;
   bit done = 0;
   // reference state
   int mt[35];
   bit m_en = 0, m_post = 0, m_step = 0;
   int m_idx = 0;
   bit p1v = 0, p2v = 0;
   int p1y[NC], p2y[NC];
   string p1t = "", p2t = "";

   task automatic chk(string tag, longint act, longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint rdiv(longint n, longint d);
      longint t = n + d / 2;
      if (t >= 0) return t / d;
      return -((-t + d - 1) / d);
   endfunction

   function automatic int ref_map(int x);
      longint lo, hi, f, d;
      if (!m_en) return x;
      if (x < 65536) begin
         lo = mt[x / 2048]; hi = mt[x / 2048 + 1]; f = x % 2048; d = 2048;
      end else if (x <= 196608) begin
         lo = mt[32]; hi = mt[33]; f = x - 65536; d = 131072;
      end else if (x <= 458752) begin
         lo = mt[33]; hi = mt[34]; f = x - 196608; d = 262144;
      end else return mt[34];
      return int'(lo + rdiv((hi - lo) * f, d));
   endfunction

   function automatic string auto_tag(int x);
      if (!m_en) return "R10 bypass";
      if (x < 65536) return "R7 segment";
      return "R8 extended";
   endfunction

   task automatic step(bit wr, int a, int d, bit pv, int x0, int x1, int x2, string tag);
      int xs[NC];
      @(negedge clk);
      chk({"R11 valid ", p2t}, pix_valid_o, p2v);
      if (p2v)
         for (int c = 0; c < NC; c++) chk(p2t, pix_o[c*XW +: XW], p2y[c]);
      xs = '{x0, x1, x2};
      p2v = p1v; p2y = p1y; p2t = p1t;
      p1v = pv;
      if (pv) begin
         for (int c = 0; c < NC; c++) p1y[c] = ref_map(xs[c]);
         p1t = (tag == "") ? auto_tag(x0) : tag;
      end
      if (wr) begin
         if (a == 0) begin m_en = d[31]; m_post = d[30]; end
         else if (a == 1) begin
            if (d[10]) m_step = 1;
            else begin m_step = 0; m_idx = ((d & 1023) >= 35) ? 35 : (d & 1023); end
         end else if (a == 2 && m_idx < 35) begin
            mt[m_idx] = d & 32'h1ffff;
            if (m_step) m_idx++;
         end
      end
      reg_wr = wr; reg_addr = 2'(a); reg_wdata = d; pix_valid_i = pv;
      for (int c = 0; c < NC; c++) pix_i[c*XW +: XW] = XW'(xs[c]);
   endtask

   task automatic wr(int a, int d);
      step(1, a, d, 0, 0, 0, 0, "");
   endtask
   task automatic rd(int a, longint exp, string tag);
      step(0, a, 0, 0, 0, 0, 0, "");
      #1 chk(tag, reg_rdata, exp);
   endtask
   task automatic px(int x0, int x1, int x2, string tag);
      step(0, 0, 0, 1, x0, x1, x2, tag);
   endtask
   task automatic flush();
      step(0, 0, 0, 0, 0, 0, 0, ""); step(0, 0, 0, 0, 0, 0, 0, "");
      step(0, 0, 0, 0, 0, 0, 0, "");
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin
      for (int i = 0; i < 35; i++) mt[i] = (i <= 32) ? i * 2048 : 65536;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(0, 0, "R1 mode");
      rd(1, 0, "R1 index");
      rd(2, 0, "R1 entry0");
      foreach (mt[i]) if (i == 1 || i == 16 || i == 32 || i == 33 || i == 34) begin
         wr(1, i);
         rd(2, (i <= 32) ? i * 2048 : 65536, "R1 identity entry");
      end
      rd(3, 0, "R2 unmapped");
      // R10 bypass while disabled
      px(0, 524287, 65536, "");
      px(12345, 200000, 458753, "");
      flush();
      // R2 mode register
      wr(0, 32'hC000_0000); rd(0, 32'hC000_0000, "R2 mode both");
      wr(0, 32'h8000_FFFF); rd(0, 32'h8000_0000, "R2 mode mask");
      // identity curve
      px(0, 2048, 1000, ""); px(65535, 65536, 100000, "");
      px(196608, 300000, 458752, ""); px(500000, 524287, 1, "");
      flush();
      // R3/R4/R5 stepped load of a custom curve
      wr(1, 0); wr(1, 32'h400);
      rd(1, 32'h400, "R4 step on idx 0");
      for (int i = 0; i < 35; i++) wr(2, (i * 7919 + 40000 * (i % 3)) % 131072);
      rd(1, 32'h400 | 35, "R5 stepped to end");
      wr(1, 7); rd(1, 7, "R3 index load"); rd(2, mt[7], "R5 stored entry");
      for (int k = 0; k < 60; k++) begin
         int x = (k * 8737 + k * k * 151) % 524288;
         if (k % 7 == 3) step(0, 0, 0, 0, 0, 0, 0, "");
         px(x, (x * 3 + 65536) % 524288, 524287 - x, "");
      end
      px(65536, 196608, 458752, "R8 breakpoints");
      px(196609, 458753, 131072, "R8 regions");
      flush();
      // R9 rounding, rising and falling
      wr(1, 0); wr(2, 0); rd(1, 0, "R5 no step");
      wr(1, 1); wr(2, 1);
      px(1024, 1023, 1025, "R9 half rising");
      wr(1, 0); wr(2, 1); wr(1, 1); wr(2, 0);
      px(1024, 1023, 1025, "R9 half falling");
      flush();
      // R4 flag write ignores index bits
      wr(1, 5); wr(1, 32'h400 | 20); rd(1, 32'h400 | 5, "R4 index kept");
      // R3/R6 saturation
      wr(1, 40); rd(1, 35, "R3 saturate"); rd(2, 0, "R6 read at 35");
      wr(2, 999); rd(1, 35, "R6 idx held");
      wr(1, 34); rd(2, mt[34], "R6 table unchanged");
      wr(1, 32'h400); wr(2, 4242); wr(2, 777);
      rd(1, 32'h400 | 35, "R6 step saturates");
      wr(1, 34); rd(2, 4242, "R6 last entry kept");
      // R11 write and pixel in the same cycle
      wr(1, 3);
      step(1, 2, 55555, 1, 6144, 6144, 6144, "R11 old entry");
      px(6144, 6144, 6144, "R11 new entry");
      step(1, 0, 0, 1, 7000, 70000, 300000, "R11 old mode");
      px(7000, 70000, 300000, "R10 after disable");
      flush();
      summary();
   end
endmodule